// File: doc/BRIEF.md
# Output Port Loopback Controller

This block runs one output port of a store-and-forward router. It takes a complete packet from the port's output buffer into a local copy. It sends the flits to the neighbouring router, then keeps the copy until the neighbour answers with an Ack or a Nack. On a Nack the whole packet goes out again from its first flit. An Ack frees the copy, and the port then accepts the next packet.

A packet can become trapped in two ways: the neighbour drops its availability flag, or the same packet is refused too many times in a row. In either case the controller steers the stored copy onto a loopback bus that feeds the router's own input path, so the router can reroute it. While this happens it raises an occupied flag that stops new traffic, and it tags the loopback with its cause. Only a loopback caused by repeated Nacks is evidence of a link or port fault.

Top module: `oport_loopback_ctrl`

## Requirements
- R1: After a synchronous reset, `up_ready` is 1, and `tx_valid`, `lb_valid` and `occupied` are 0.
- R2: While idle (`up_ready` = 1) the block accepts one flit per cycle in which `up_valid` is 1. A packet is complete at a flit with `up_last` = 1, or at the DEPTH-th flit (default 8), whichever comes first. `up_ready` stays 0 from then until that packet has been freed by an Ack or fully looped back, and in that span neither `tx_valid` nor `lb_valid` is high together with `up_ready`.
- R3: Flits go to the neighbour in arrival order. One flit advances in each cycle with `tx_valid` and `nb_ready` both high. `tx_last` is 1 on the final flit.
- R4: After the final flit the block waits for a response. An Ack frees the packet, and `up_ready` is 1 in the cycle after the Ack.
- R5: A Nack while waiting resends the whole packet from its first flit. When Ack and Nack arrive in the same cycle, the Ack wins.
- R6: After NACK_LIMIT consecutive Nacks (default 3) on one packet, the packet is looped back with `lb_cause` = 1.
- R7: If `nb_avail` is 0 while the block is sending or waiting, the packet is looped back from its first flit with `lb_cause` = 0. `tx_valid` is never 1 while `nb_avail` is 0.
- R8: During a loopback the flits appear in order on `lb_data`. Each flit advances when `lb_ready` is 1, `lb_last` marks the final flit, and `occupied` is 1 for the whole loopback. The loopback outputs hold their values while `lb_ready` is 0. Afterwards `up_ready` returns to 1.
- R9: The Nack count restarts with every new packet, so Nacks taken by an earlier, acknowledged packet never add to the count of a later one.
- R10: Ack and Nack have no effect outside the waiting phase: the send in progress and the idle state both continue unchanged.
- R11: `tx_valid` and `lb_valid` are never high together, and `tx_data` holds its value while the neighbour stalls with `nb_ready` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_valid | input | 1 | Output buffer presents a flit |
| up_data | input | W | Flit from the output buffer |
| up_last | input | 1 | Flit is the last of its packet |
| up_ready | output | 1 | Block takes the presented flit |
| nb_avail | input | 1 | Neighbour input port is available |
| nb_ready | input | 1 | Neighbour accepts a flit this cycle |
| tx_valid | output | 1 | Flit offered to the neighbour |
| tx_data | output | W | Flit to the neighbour |
| tx_last | output | 1 | Offered flit is the last of the packet |
| ack | input | 1 | Neighbour received the packet intact |
| nack | input | 1 | Neighbour rejected the packet |
| lb_ready | input | 1 | Local input path accepts a looped flit |
| lb_valid | output | 1 | Flit offered on the loopback bus |
| lb_data | output | W | Looped-back flit |
| lb_last | output | 1 | Looped flit is the last of the packet |
| lb_cause | output | 1 | Loopback cause: 1 after repeated Nacks, 0 for an unavailable neighbour |
| occupied | output | 1 | Port busy with a loopback; no new traffic |

## Verification
A wrong sequencing state shows at the ports in the same cycle or the next one. Typical symptoms are a `tx_valid` with no stored packet, an `up_ready` while a copy is still held, or a loopback that starts with no cause. A corrupted flit index shows as a wrong or reordered word on `tx_data` or `lb_data`, or as `tx_last` or `lb_last` on the wrong flit, on the first flit it affects. A Nack count that is off or never cleared stays hidden until the next Nack burst. It then shows as a loopback one retry too early or too late, or as a missing `lb_cause` = 1.

// File: rtl/oplb_pkg.sv
package oplb_pkg;
  typedef enum logic [1:0] {
    ST_LOAD = 2'd0,
    ST_SEND = 2'd1,
    ST_WAIT = 2'd2,
    ST_LOOP = 2'd3
  } oplb_state_e;

  localparam logic CAUSE_UNAVAIL = 1'b0;
  localparam logic CAUSE_NACK    = 1'b1;
endpackage

// File: rtl/oplb_pkt_store.sv
module oplb_pkt_store #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/oplb_nack_ctr.sv
module oplb_nack_ctr #(
  parameter int LIMIT = 3,
  localparam int CW   = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic hit
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc && cnt != CW'(LIMIT)) cnt <= cnt + 1'b1;
  end

  // this Nack would be the LIMIT-th in a row
  assign hit = (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/oport_loopback_ctrl.sv
module oport_loopback_ctrl
  import oplb_pkg::*;
#(
  parameter int W          = 16,
  parameter int DEPTH      = 8,
  parameter int NACK_LIMIT = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         up_valid,
  input  logic [W-1:0] up_data,
  input  logic         up_last,
  output logic         up_ready,
  input  logic         nb_avail,
  input  logic         nb_ready,
  output logic         tx_valid,
  output logic [W-1:0] tx_data,
  output logic         tx_last,
  input  logic         ack,
  input  logic         nack,
  input  logic         lb_ready,
  output logic         lb_valid,
  output logic [W-1:0] lb_data,
  output logic         lb_last,
  output logic         lb_cause,
  output logic         occupied
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  oplb_state_e   state;
  logic [AW-1:0] wr_idx, rd_idx, last_idx;
  logic          cause_q;
  logic [W-1:0]  rdata;
  logic          nack_hit;

  logic load_fire, load_done, at_last, cnt_clr, cnt_inc;

  assign load_fire = (state == ST_LOAD) && up_valid;
  assign load_done = load_fire && (up_last || wr_idx == AW'(DEPTH - 1));
  assign at_last   = (rd_idx == last_idx);
  assign cnt_inc   = (state == ST_WAIT) && nack && !ack;
  assign cnt_clr   = load_done || ((state == ST_WAIT) && ack);

  oplb_pkt_store #(.W(W), .DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .we    (load_fire),
    .waddr (wr_idx),
    .wdata (up_data),
    .raddr (rd_idx),
    .rdata (rdata)
  );

  oplb_nack_ctr #(.LIMIT(NACK_LIMIT)) u_nack (
    .clk (clk),
    .rst (rst),
    .clr (cnt_clr),
    .inc (cnt_inc),
    .hit (nack_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_LOAD;
      wr_idx   <= '0;
      rd_idx   <= '0;
      last_idx <= '0;
      cause_q  <= CAUSE_UNAVAIL;
    end else begin
      unique case (state)
        ST_LOAD: if (load_fire) begin
          if (load_done) begin
            last_idx <= wr_idx;
            wr_idx   <= '0;
            rd_idx   <= '0;
            state    <= ST_SEND;
          end else begin
            wr_idx <= wr_idx + 1'b1;
          end
        end
        ST_SEND: begin
          if (!nb_avail) begin
            cause_q <= CAUSE_UNAVAIL;
            rd_idx  <= '0;
            state   <= ST_LOOP;
          end else if (nb_ready) begin
            if (at_last) begin
              rd_idx <= '0;
              state  <= ST_WAIT;
            end else begin
              rd_idx <= rd_idx + 1'b1;
            end
          end
        end
        ST_WAIT: begin
          rd_idx <= '0;
          if (ack) begin
            state <= ST_LOAD;
          end else if (nack) begin
            if (nack_hit) begin
              cause_q <= CAUSE_NACK;
              state   <= ST_LOOP;
            end else begin
              state <= ST_SEND;
            end
          end else if (!nb_avail) begin
            cause_q <= CAUSE_UNAVAIL;
            state   <= ST_LOOP;
          end
        end
        ST_LOOP: if (lb_ready) begin
          if (at_last) begin
            rd_idx <= '0;
            state  <= ST_LOAD;
          end else begin
            rd_idx <= rd_idx + 1'b1;
          end
        end
        default: state <= ST_LOAD;
      endcase
    end
  end

  assign up_ready = (state == ST_LOAD);
  assign tx_valid = (state == ST_SEND) && nb_avail;
  assign tx_data  = rdata;
  assign tx_last  = at_last;
  assign lb_valid = (state == ST_LOOP);
  assign lb_data  = rdata;
  assign lb_last  = at_last;
  assign lb_cause = cause_q;
  assign occupied = (state == ST_LOOP);
endmodule

// File: rtl/oplb_chk.sv
module oplb_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         up_ready,
  input logic         nb_avail,
  input logic         nb_ready,
  input logic         tx_valid,
  input logic [W-1:0] tx_data,
  input logic         lb_ready,
  input logic         lb_valid,
  input logic [W-1:0] lb_data,
  input logic         lb_last,
  input logic         lb_cause,
  input logic         occupied
);
  AST_EXCL_PATHS: assert property (@(posedge clk) disable iff (rst) !(tx_valid && lb_valid)); // R11
  AST_LOAD_QUIET: assert property (@(posedge clk) disable iff (rst) up_ready |-> (!tx_valid && !lb_valid)); // R2
  AST_OCC_LOOP: assert property (@(posedge clk) disable iff (rst) lb_valid |-> occupied); // R8
  AST_NO_TX_UNAVAIL: assert property (@(posedge clk) disable iff (rst) !nb_avail |-> !tx_valid); // R7
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !nb_ready) |=> (!tx_valid || $stable(tx_data))); // R11
  AST_LB_HOLD: assert property (@(posedge clk) disable iff (rst)
    (lb_valid && !lb_ready) |=> (lb_valid && $stable(lb_data) && $stable(lb_last) && $stable(lb_cause))); // R8
endmodule

bind oport_loopback_ctrl oplb_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .up_ready (up_ready),
  .nb_avail (nb_avail),
  .nb_ready (nb_ready),
  .tx_valid (tx_valid),
  .tx_data  (tx_data),
  .lb_ready (lb_ready),
  .lb_valid (lb_valid),
  .lb_data  (lb_data),
  .lb_last  (lb_last),
  .lb_cause (lb_cause),
  .occupied (occupied)
);

// File: tb/tb_oport_loopback_ctrl.sv
module tb_oport_loopback_ctrl;
  localparam int W = 16;
  localparam int DEPTH = 8;
  localparam int LIM = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic         up_valid = 0, up_last = 0, nb_avail = 1, nb_ready = 1;
  logic         ack = 0, nack = 0, lb_ready = 1;
  logic [W-1:0] up_data = '0;
  logic         up_ready, tx_valid, tx_last, lb_valid, lb_last, lb_cause, occupied;
  logic [W-1:0] tx_data, lb_data;
  bit           nb_stall = 0, lb_stall = 0;

  oport_loopback_ctrl #(.W(W), .DEPTH(DEPTH), .NACK_LIMIT(LIM)) dut (
    .clk(clk), .rst(rst), .up_valid(up_valid), .up_data(up_data), .up_last(up_last),
    .up_ready(up_ready), .nb_avail(nb_avail), .nb_ready(nb_ready), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_last(tx_last), .ack(ack), .nack(nack), .lb_ready(lb_ready),
    .lb_valid(lb_valid), .lb_data(lb_data), .lb_last(lb_last), .lb_cause(lb_cause),
    .occupied(occupied)
  );

  int checks = 0, failures = 0;
  int tx_cnt = 0, lb_cnt = 0, lb_seen_cause = -1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural reference: 0 idle/load, 1 send, 2 await response, 3 loopback
  int m_mode = 0, m_idx = 0, m_nacks = 0, m_cause = 0;
  int m_q[$];

  always @(posedge clk) begin
    if (rst) begin
      m_mode = 0; m_idx = 0; m_nacks = 0; m_cause = 0; m_q.delete();
    end else begin
      case (m_mode)
        0: if (up_valid) begin
          m_q.push_back(int'(up_data));
          if (up_last || m_q.size() == DEPTH) begin
            m_mode = 1; m_idx = 0; m_nacks = 0;
          end
        end
        1: if (!nb_avail) begin
          m_mode = 3; m_cause = 0; m_idx = 0;
        end else if (nb_ready) begin
          if (m_idx == m_q.size() - 1) begin m_mode = 2; m_idx = 0; end
          else m_idx++;
        end
        2: if (ack) begin
          m_mode = 0; m_q.delete(); m_nacks = 0;
        end else if (nack) begin
          m_nacks++; m_idx = 0;
          if (m_nacks == LIM) begin m_mode = 3; m_cause = 1; end
          else m_mode = 1;
        end else if (!nb_avail) begin
          m_mode = 3; m_cause = 0; m_idx = 0;
        end
        default: if (lb_ready) begin
          if (m_idx == m_q.size() - 1) begin m_mode = 0; m_q.delete(); end
          else m_idx++;
        end
      endcase
    end
  end

  always @(negedge clk) begin
    nb_ready <= nb_stall ? ~nb_ready : 1'b1;
    lb_ready <= lb_stall ? ~lb_ready : 1'b1;
  end

  // per-cycle comparison against the reference, away from the active edge
  always @(negedge clk) begin
    #1;
    if (!rst) begin
      bit e_tx, e_lb;
      e_tx = (m_mode == 1) && nb_avail;
      e_lb = (m_mode == 3);
      chk(up_ready === (m_mode == 0), "R2 up_ready", int'(up_ready), int'(m_mode == 0));
      chk(tx_valid === e_tx, "R3 tx_valid", int'(tx_valid), int'(e_tx));
      if (e_tx) begin
        chk(tx_data === W'(m_q[m_idx]), "R3 tx_data", int'(tx_data), m_q[m_idx]);
        chk(tx_last === (m_idx == m_q.size() - 1), "R3 tx_last", int'(tx_last),
            int'(m_idx == m_q.size() - 1));
      end
      chk(lb_valid === e_lb, "R8 lb_valid", int'(lb_valid), int'(e_lb));
      chk(occupied === e_lb, "R8 occupied", int'(occupied), int'(e_lb));
      if (e_lb) begin
        chk(lb_data === W'(m_q[m_idx]), "R8 lb_data", int'(lb_data), m_q[m_idx]);
        chk(lb_last === (m_idx == m_q.size() - 1), "R8 lb_last", int'(lb_last),
            int'(m_idx == m_q.size() - 1));
        chk(int'(lb_cause) == m_cause, "R6_R7 lb_cause", int'(lb_cause), m_cause);
      end
      if (tx_valid && nb_ready) tx_cnt++;
      if (lb_valid && lb_ready) begin lb_cnt++; lb_seen_cause = int'(lb_cause); end
    end
  end

  task automatic push_pkt(input int n, input int base, input bit mark_last);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      up_valid = 1; up_data = W'(base + i); up_last = mark_last && (i == n - 1);
      #1;
      while (!up_ready) begin @(negedge clk); #1; end
    end
    @(negedge clk);
    up_valid = 0; up_last = 0;
  endtask

  task automatic wait_mode(input int md);
    while (m_mode != md) @(negedge clk);
  endtask

  task automatic respond(input bit a, input bit n);
    @(negedge clk); ack = a; nack = n;
    @(negedge clk); ack = 0; nack = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int t0, l0;
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    chk(up_ready === 1'b1, "R1 up_ready", int'(up_ready), 1);
    chk(tx_valid === 1'b0, "R1 tx_valid", int'(tx_valid), 0);
    chk(lb_valid === 1'b0, "R1 lb_valid", int'(lb_valid), 0);
    chk(occupied === 1'b0, "R1 occupied", int'(occupied), 0);

    // plain packet, Ack two cycles after the last flit
    t0 = tx_cnt;
    push_pkt(3, 16'h100, 1);
    wait_mode(2);
    chk(tx_cnt - t0 == 3, "R3 flits sent", tx_cnt - t0, 3);
    repeat (2) @(negedge clk);
    respond(1, 0); #1;
    chk(up_ready === 1'b1, "R4 freed after ack", int'(up_ready), 1);

    // neighbour stalls every other cycle
    nb_stall = 1; t0 = tx_cnt;
    push_pkt(4, 16'h200, 1);
    wait_mode(2); nb_stall = 0;
    chk(tx_cnt - t0 == 4, "R11 stalled send", tx_cnt - t0, 4);
    respond(1, 0);

    // single Nack, then Ack and Nack together
    t0 = tx_cnt;
    push_pkt(2, 16'h300, 1);
    wait_mode(2); respond(0, 1); wait_mode(2);
    chk(tx_cnt - t0 == 4, "R5 full resend", tx_cnt - t0, 4);
    respond(1, 1); #1;
    chk(up_ready === 1'b1, "R5 ack wins", int'(up_ready), 1);

    // three Nacks in a row -> loopback, cause 1, with stalled loop sink
    t0 = tx_cnt; l0 = lb_cnt;
    push_pkt(3, 16'h400, 1);
    for (int k = 0; k < LIM; k++) begin wait_mode(2); respond(0, 1); end
    lb_stall = 1;
    wait_mode(0); lb_stall = 0;
    chk(tx_cnt - t0 == 9, "R6 three attempts", tx_cnt - t0, 9);
    chk(lb_cnt - l0 == 3, "R6 looped flits", lb_cnt - l0, 3);
    chk(lb_seen_cause == 1, "R6 cause nack", lb_seen_cause, 1);

    // two packets, two Nacks each: count must restart
    l0 = lb_cnt;
    for (int p = 0; p < 2; p++) begin
      push_pkt(2, 16'h500 + 16 * p, 1);
      wait_mode(2); respond(0, 1);
      wait_mode(2); respond(0, 1);
      wait_mode(2); respond(1, 0);
    end
    chk(lb_cnt - l0 == 0, "R9 no loop", lb_cnt - l0, 0);

    // neighbour lost in mid-send
    nb_stall = 1; l0 = lb_cnt;
    push_pkt(5, 16'h600, 1);
    wait_mode(1); repeat (3) @(negedge clk);
    nb_avail = 0;
    wait_mode(0); nb_avail = 1; nb_stall = 0;
    chk(lb_cnt - l0 == 5, "R7 loop during send", lb_cnt - l0, 5);
    chk(lb_seen_cause == 0, "R7 cause unavail", lb_seen_cause, 0);

    // neighbour lost while awaiting response
    l0 = lb_cnt;
    push_pkt(2, 16'h700, 1);
    wait_mode(2); @(negedge clk); nb_avail = 0;
    wait_mode(0); nb_avail = 1;
    chk(lb_cnt - l0 == 2, "R7 loop during wait", lb_cnt - l0, 2);
    chk(lb_seen_cause == 0, "R7 cause unavail", lb_seen_cause, 0);

    // neighbour already unavailable when the packet arrives
    nb_avail = 0; l0 = lb_cnt; t0 = tx_cnt;
    push_pkt(2, 16'h780, 1);
    wait_mode(0); nb_avail = 1;
    chk(lb_cnt - l0 == 2 && tx_cnt == t0, "R7 never sent", lb_cnt - l0, 2);

    // no up_last: packet closes at DEPTH flits
    t0 = tx_cnt;
    push_pkt(DEPTH, 16'h800, 0); #1;
    chk(up_ready === 1'b0, "R2 closed at depth", int'(up_ready), 0);
    wait_mode(2);
    chk(tx_cnt - t0 == DEPTH, "R2 depth flits", tx_cnt - t0, DEPTH);
    respond(1, 0);
    t0 = tx_cnt;
    push_pkt(2, 16'h808, 1);
    wait_mode(2);
    chk(tx_cnt - t0 == 2, "R2 tail packet", tx_cnt - t0, 2);
    respond(1, 0);

    // responses outside the waiting phase
    respond(1, 1); #1;
    chk(up_ready === 1'b1 && tx_valid === 1'b0, "R10 idle ignores", int'(up_ready), 1);
    nb_stall = 1; t0 = tx_cnt;
    push_pkt(4, 16'h900, 1);
    wait_mode(1); respond(0, 1); respond(1, 0);
    wait_mode(2); nb_stall = 0; #1;
    chk(tx_cnt - t0 == 4, "R10 send unaffected", tx_cnt - t0, 4);
    chk(up_ready === 1'b0, "R10 still held", int'(up_ready), 0);
    respond(1, 0);

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule